// File: doc/BRIEF.md
# Ethernet Flow-Control Pause Frame Generator

This block builds complete MAC control pause frames and streams them out one octet per clock toward a byte-wide transmit path. Four kinds of event start a frame. Two of them ask the link partner to stop: the receive buffer fill level rising to a programmable threshold, and a rising edge on a stop input pin. Two of them ask the partner to resume: a rising edge on a resume input pin, and a write that sets the resume control bit. A separate stop-hold control bit makes the block send stop frames one after another for as long as the bit stays set.

A stop (XOFF) frame carries the programmed pause time. A resume (XON) frame carries a pause time of zero. The block does not own the transmit path. It raises a request toward the transmit arbiter, waits for a grant and then sends the whole 72-octet frame without a break: preamble, start delimiter, the reserved control multicast destination address, the station source address, the control type, the pause opcode, the pause time, zero padding and the frame check sequence. Events that arrive while a frame is on the wire are held and served in turn. When stop and resume are pending together, stop goes first.

Top module: `pause_frame_gen`

## Requirements
- R1: A frame starts on the cycle after a grant. It opens with seven octets of 0x55 followed by one octet of 0xD5, and `tx_en` stays high without a gap for all 72 octets.
- R2: Octets 8..13 are 01 80 C2 00 00 01. Octets 14..19 are `station_addr`, most significant octet first, as captured on the grant cycle.
- R3: Octets 20..23 are 0x88, 0x08, 0x00, 0x01.
- R4: Octets 24..25 carry the pause time, most significant octet first. An XOFF frame carries `pause_quanta` as captured on the grant cycle. An XON frame carries 0x0000.
- R5: Octets 26..67 are all 0x00. A frame is exactly 72 octets long, and `tx_en` is low on the cycle after its last octet.
- R6: Octets 68..71 are the CRC-32 of octets 8..67, sent complemented and low-order octet first. The CRC uses the reflected polynomial 0xEDB88320 and an all-ones start value.
- R7: A rising edge of (`fill_level` >= `fill_thresh`) or of `pin_xoff` requests one XOFF frame. A rising edge of `pin_xon` or of `xon_wr` requests one XON frame. A level that stays high does not request again.
- R8: While `xoff_hold` is 1, XOFF frames are sent back to back: the next request rises on the cycle after the previous frame's last octet. After the bit clears, no further frames are started for it.
- R9: With the block idle and a reason to send, `tx_req` rises on the next cycle. It stays high until `tx_gnt` is sampled high. It falls without a frame if every reason has gone before the grant. `tx_req` and `tx_en` are never high together.
- R10: When XOFF and XON are both pending, the XOFF frame goes first, and the XON request is kept and sent next.
- R11: An event that arrives while a frame is being sent is held and produces its frame after the current one ends.
- R12: After a synchronous reset, `tx_req` and `tx_en` are low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_level | input | LVL_W | Receive buffer fill level |
| fill_thresh | input | LVL_W | Fill level at which an XOFF frame is requested |
| pin_xoff | input | 1 | Stop request pin, rising-edge triggered |
| pin_xon | input | 1 | Resume request pin, rising-edge triggered |
| xoff_hold | input | 1 | Control bit: repeat XOFF frames while set |
| xon_wr | input | 1 | Control bit: a rising edge requests one XON frame |
| pause_quanta | input | 16 | Pause time placed in XOFF frames |
| station_addr | input | 48 | Source MAC address, first transmitted octet in bits 47:40 |
| tx_gnt | input | 1 | Grant from the transmit arbiter |
| tx_req | output | 1 | Request for the transmit path |
| tx_en | output | 1 | Octet valid on `tx_data` |
| tx_data | output | 8 | Transmit octet |

## Verification
The bench's reference model has its own counters for the frame position. A position counter in the design that goes off by one shows up at once as a wrong octet at the preamble, type or pad boundary. A CRC state that goes wrong corrupts only the last four octets. The first wrong value therefore appears at octet 68, about sixty cycles after the fault. A pending flag that is lost or left set does not corrupt any octet. It shows up as a missing or extra frame, or as a frame with the wrong pause time, about 75 cycles later when the next request should or should not rise. The bench therefore checks the sequence of pause times across each scenario as well as comparing every cycle.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  localparam int SFD_IDX   = 7;
  localparam int DA_IDX    = 8;
  localparam int SA_IDX    = 14;
  localparam int TYPE_IDX  = 20;
  localparam int QNT_IDX   = 24;
  localparam int PAD_IDX   = 26;
  localparam int PAD_LEN   = 42;
  localparam int FCS_IDX   = PAD_IDX + PAD_LEN;
  localparam int FCS_LEN   = 4;
  localparam int FRAME_LEN = FCS_IDX + FCS_LEN;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  localparam logic [7:0]  PRE_BYTE  = 8'h55;
  localparam logic [7:0]  SFD_BYTE  = 8'hD5;
  localparam logic [47:0] CTRL_DA   = 48'h0180C2000001;
  localparam logic [31:0] TYPE_OPC  = 32'h88080001;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_SEND
  } pfg_state_t;

  // One octet through the reflected CRC-32 register.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/pfg_trigger.sv
module pfg_trigger #(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] fill_thresh,
  input  logic             pin_xoff,
  input  logic             pin_xon,
  input  logic             xon_wr,
  input  logic             take_xoff,
  input  logic             take_xon,
  output logic             pend_xoff,
  output logic             pend_xon
);

  // Sources 0..1 ask for XOFF, 2..3 ask for XON.
  localparam int NSRC = 4;
  localparam int NOFF = 2;

  logic [NSRC-1:0] lvl;
  logic [NSRC-1:0] lvl_d;
  logic [NSRC-1:0] rise;
  logic            ev_xoff;
  logic            ev_xon;

  assign lvl = {xon_wr, pin_xon, pin_xoff, (fill_level >= fill_thresh)};

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_edge
    assign rise[g] = lvl[g] & ~lvl_d[g];
  end

  assign ev_xoff = |rise[NOFF-1:0];
  assign ev_xon  = |rise[NSRC-1:NOFF];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_xoff <= 1'b0;
      pend_xon  <= 1'b0;
    end else begin
      pend_xoff <= (pend_xoff & ~take_xoff) | ev_xoff;
      pend_xon  <= (pend_xon  & ~take_xon)  | ev_xon;
    end
  end

endmodule

// File: rtl/pfg_crc32.sv
module pfg_crc32 (
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import pfg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || init) crc <= '1;
    else if (en)     crc <= crc_step(crc, din);
  end

endmodule

// File: rtl/pfg_framer.sv
module pfg_framer (
  input  logic        clk,
  input  logic        rst,
  input  logic        pend_xoff,
  input  logic        pend_xon,
  input  logic        xoff_hold,
  input  logic [15:0] pause_quanta,
  input  logic [47:0] station_addr,
  input  logic        tx_gnt,
  input  logic [31:0] crc_val,
  output logic        take_xoff,
  output logic        take_xon,
  output logic        crc_init,
  output logic        crc_en,
  output logic [7:0]  crc_din,
  output logic        tx_req,
  output logic        tx_en,
  output logic [7:0]  tx_data
);
  import pfg_pkg::*;

  pfg_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rel;
  logic [15:0]      quanta_q;
  logic [47:0]      sa_q;
  logic [7:0]       cur_byte;
  logic             want_xoff;
  logic             has_reason;
  logic             start;

  assign want_xoff  = pend_xoff | xoff_hold;
  assign has_reason = want_xoff | pend_xon;
  assign start      = (state == ST_REQ) && has_reason && tx_gnt;
  assign take_xoff  = start & pend_xoff;
  assign take_xon   = start & ~want_xoff;

  // Octet for the current frame position.
  always_comb begin
    rel      = '0;
    cur_byte = 8'h00;
    if (idx < IDX_W'(SFD_IDX)) begin
      cur_byte = PRE_BYTE;
    end else if (idx == IDX_W'(SFD_IDX)) begin
      cur_byte = SFD_BYTE;
    end else if (idx < IDX_W'(SA_IDX)) begin
      rel      = idx - IDX_W'(DA_IDX);
      cur_byte = 8'(CTRL_DA >> {IDX_W'(5) - rel, 3'b000});
    end else if (idx < IDX_W'(TYPE_IDX)) begin
      rel      = idx - IDX_W'(SA_IDX);
      cur_byte = 8'(sa_q >> {IDX_W'(5) - rel, 3'b000});
    end else if (idx < IDX_W'(QNT_IDX)) begin
      rel      = idx - IDX_W'(TYPE_IDX);
      cur_byte = 8'(TYPE_OPC >> {IDX_W'(3) - rel, 3'b000});
    end else if (idx < IDX_W'(PAD_IDX)) begin
      rel      = idx - IDX_W'(QNT_IDX);
      cur_byte = 8'(quanta_q >> {IDX_W'(1) - rel, 3'b000});
    end else if (idx < IDX_W'(FCS_IDX)) begin
      cur_byte = 8'h00;
    end else begin
      rel      = idx - IDX_W'(FCS_IDX);
      cur_byte = 8'(~crc_val >> {rel, 3'b000});
    end
  end

  assign crc_init = start;
  assign crc_din  = cur_byte;
  assign crc_en   = (state == ST_SEND) && (idx >= IDX_W'(DA_IDX)) && (idx < IDX_W'(FCS_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      quanta_q <= '0;
      sa_q     <= '0;
      tx_req   <= 1'b0;
      tx_en    <= 1'b0;
      tx_data  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tx_en   <= 1'b0;
          tx_data <= '0;
          if (has_reason) begin
            state  <= ST_REQ;
            tx_req <= 1'b1;
          end
        end
        ST_REQ: begin
          if (!has_reason) begin
            state  <= ST_IDLE;
            tx_req <= 1'b0;
          end else if (tx_gnt) begin
            state    <= ST_SEND;
            tx_req   <= 1'b0;
            tx_en    <= 1'b1;
            tx_data  <= PRE_BYTE;
            idx      <= IDX_W'(1);
            quanta_q <= want_xoff ? pause_quanta : 16'h0000;
            sa_q     <= station_addr;
          end
        end
        ST_SEND: begin
          tx_en   <= 1'b1;
          tx_data <= cur_byte;
          if (idx == IDX_W'(FRAME_LEN - 1)) state <= ST_IDLE;
          else                              idx   <= idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen #(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] fill_thresh,
  input  logic             pin_xoff,
  input  logic             pin_xon,
  input  logic             xoff_hold,
  input  logic             xon_wr,
  input  logic [15:0]      pause_quanta,
  input  logic [47:0]      station_addr,
  input  logic             tx_gnt,
  output logic             tx_req,
  output logic             tx_en,
  output logic [7:0]       tx_data
);

  logic        pend_xoff;
  logic        pend_xon;
  logic        take_xoff;
  logic        take_xon;
  logic        crc_init;
  logic        crc_en;
  logic [7:0]  crc_din;
  logic [31:0] crc_val;

  pfg_trigger #(.LVL_W(LVL_W)) u_trig (
    .clk         (clk),
    .rst         (rst),
    .fill_level  (fill_level),
    .fill_thresh (fill_thresh),
    .pin_xoff    (pin_xoff),
    .pin_xon     (pin_xon),
    .xon_wr      (xon_wr),
    .take_xoff   (take_xoff),
    .take_xon    (take_xon),
    .pend_xoff   (pend_xoff),
    .pend_xon    (pend_xon)
  );

  pfg_crc32 u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (crc_init),
    .en   (crc_en),
    .din  (crc_din),
    .crc  (crc_val)
  );

  pfg_framer u_frm (
    .clk          (clk),
    .rst          (rst),
    .pend_xoff    (pend_xoff),
    .pend_xon     (pend_xon),
    .xoff_hold    (xoff_hold),
    .pause_quanta (pause_quanta),
    .station_addr (station_addr),
    .tx_gnt       (tx_gnt),
    .crc_val      (crc_val),
    .take_xoff    (take_xoff),
    .take_xon     (take_xon),
    .crc_init     (crc_init),
    .crc_en       (crc_en),
    .crc_din      (crc_din),
    .tx_req       (tx_req),
    .tx_en        (tx_en),
    .tx_data      (tx_data)
  );

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker (
  input logic       clk,
  input logic       rst,
  input logic       tx_gnt,
  input logic       tx_req,
  input logic       tx_en,
  input logic [7:0] tx_data,
  input logic       xoff_hold,
  input logic       pend_xoff,
  input logic       pend_xon
);
  import pfg_pkg::*;

  logic [7:0] pos;
  logic       reason;

  assign reason = pend_xoff | pend_xon | xoff_hold;

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else     pos <= tx_en ? pos + 8'd1 : 8'd0;
  end

  AST_REQ_NOT_SENDING: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> !tx_en);                                             // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_gnt && reason) |=> tx_req);                      // R9
  AST_GRANT_START: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_gnt && reason) |=> $rose(tx_en));                 // R1
  AST_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
    (tx_en && pos < 8'(SFD_IDX)) |-> tx_data == PRE_BYTE);          // R1
  AST_SFD: assert property (@(posedge clk) disable iff (rst)
    (tx_en && pos == 8'(SFD_IDX)) |-> tx_data == SFD_BYTE);         // R1
  AST_TYPE_HI: assert property (@(posedge clk) disable iff (rst)
    (tx_en && pos == 8'(TYPE_IDX)) |-> tx_data == 8'h88);           // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tx_en && pos >= 8'(PAD_IDX) && pos < 8'(FCS_IDX)) |-> tx_data == 8'h00); // R5
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> pos == 8'(FRAME_LEN));                         // R5
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> pos < 8'(FRAME_LEN));                                 // R5

endmodule

bind pause_frame_gen pfg_checker u_chk (.*);

// File: tb/pause_frame_gen_test.sv
module pause_frame_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 12;
  localparam int FLEN       = 72;
  localparam int WDOG       = 60000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LVL_W-1:0] fill_level = '0;
  logic [LVL_W-1:0] fill_thresh = 12'd100;
  logic             pin_xoff = 1'b0;
  logic             pin_xon = 1'b0;
  logic             xoff_hold = 1'b0;
  logic             xon_wr = 1'b0;
  logic [15:0]      pause_quanta = 16'h1234;
  logic [47:0]      station_addr = 48'h0A1B2C3D4E5F;
  logic             tx_gnt = 1'b0;
  logic             tx_req;
  logic             tx_en;
  logic [7:0]       tx_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int gnt_lat = 0;
  int gnt_wait = 0;

  pause_frame_gen #(.LVL_W(LVL_W)) uut (
    .clk(clk), .rst(rst), .fill_level(fill_level), .fill_thresh(fill_thresh),
    .pin_xoff(pin_xoff), .pin_xon(pin_xon), .xoff_hold(xoff_hold), .xon_wr(xon_wr),
    .pause_quanta(pause_quanta), .station_addr(station_addr), .tx_gnt(tx_gnt),
    .tx_req(tx_req), .tx_en(tx_en), .tx_data(tx_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- reference model ----------------
  int         m_state = 0;   // 0 idle, 1 requesting, 2 sending
  bit         m_px = 0, m_pn = 0;
  bit [3:0]   m_prev = '0;
  bit         m_req = 0, m_en = 0;
  logic [7:0] m_data = '0;
  int         m_pos = 0;
  int         m_next = 0;
  logic [7:0] m_frame [FLEN];

  task automatic build_frame(input bit is_xoff, input logic [15:0] q, input logic [47:0] sa);
    logic [47:0] da;
    logic [31:0] r;
    bit          fb;
    da = 48'h0180C2000001;
    for (int i = 0; i < 7; i++) m_frame[i] = 8'h55;
    m_frame[7] = 8'hD5;
    for (int i = 0; i < 6; i++) begin
      m_frame[8 + i]  = da[47 - 8*i -: 8];
      m_frame[14 + i] = sa[47 - 8*i -: 8];
    end
    m_frame[20] = 8'h88; m_frame[21] = 8'h08;
    m_frame[22] = 8'h00; m_frame[23] = 8'h01;
    m_frame[24] = is_xoff ? q[15:8] : 8'h00;
    m_frame[25] = is_xoff ? q[7:0]  : 8'h00;
    for (int i = 26; i < 68; i++) m_frame[i] = 8'h00;
    r = 32'hFFFFFFFF;
    for (int i = 8; i < 68; i++) begin
      for (int b = 0; b < 8; b++) begin
        fb = r[0] ^ m_frame[i][b];
        r  = {1'b0, r[31:1]};
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    r = ~r;
    for (int k = 0; k < 4; k++) m_frame[68 + k] = r[8*k +: 8];
  endtask

  always @(posedge clk) begin
    bit thr, evx, evn, tkx, tkn, reason, wx;
    if (rst) begin
      m_state = 0; m_px = 0; m_pn = 0; m_prev = '0;
      m_req = 0; m_en = 0; m_data = '0; m_next = 0; m_pos = 0;
    end else begin
      thr = (fill_level >= fill_thresh);
      evx = (thr & !m_prev[0]) | (pin_xoff & !m_prev[1]);
      evn = (pin_xon & !m_prev[2]) | (xon_wr & !m_prev[3]);
      tkx = 0; tkn = 0;
      wx = m_px | xoff_hold;
      reason = wx | m_pn;
      case (m_state)
        0: begin
          m_en = 0;
          if (reason) begin m_state = 1; m_req = 1; end
        end
        1: begin
          if (!reason) begin
            m_state = 0; m_req = 0;
          end else if (tx_gnt) begin
            build_frame(wx, pause_quanta, station_addr);
            tkx = m_px; tkn = !wx;
            m_state = 2; m_req = 0; m_en = 1;
            m_data = m_frame[0]; m_pos = 0; m_next = 1;
          end
        end
        default: begin
          m_en = 1; m_data = m_frame[m_next]; m_pos = m_next;
          if (m_next == FLEN - 1) m_state = 0;
          else m_next++;
        end
      endcase
      m_px = (m_px & !tkx) | evx;
      m_pn = (m_pn & !tkn) | evn;
      m_prev = {xon_wr, pin_xon, pin_xoff, thr};
    end
  end

  // ---------------- comparison, grant and monitor ----------------
  logic [7:0] obs_hi = '0;
  int         obs_pos = 0;
  int         obs_q [$];

  function automatic string pos_req(input int p);
    if (p < 8)  return "R1";
    if (p < 20) return "R2";
    if (p < 24) return "R3";
    if (p < 26) return "R4";
    if (p < 68) return "R5";
    return "R6";
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(tx_req == m_req, "R9", "tx_req", int'(tx_req), int'(m_req));
      chk(tx_en == m_en, "R5", "tx_en", int'(tx_en), int'(m_en));
      if (m_en && tx_en)
        chk(tx_data == m_data, pos_req(m_pos), "tx_data", int'(tx_data), int'(m_data));
      if (tx_en) begin
        if (obs_pos == 24) obs_hi = tx_data;
        if (obs_pos == 25) obs_q.push_back({obs_hi, tx_data});
        obs_pos++;
      end else begin
        obs_pos = 0;
      end
      if (tx_req) begin
        if (gnt_wait >= gnt_lat) tx_gnt <= 1'b1;
        else gnt_wait++;
      end else begin
        gnt_wait = 0;
        tx_gnt <= 1'b0;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expect_seq(input string req, input int exp []);
    chk(obs_q.size() == exp.size(), req, "frame count", obs_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < obs_q.size(); i++)
      chk(obs_q[i] == exp[i], req, "pause time", obs_q[i], exp[i]);
    obs_q.delete();
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R12: quiet after reset
    chk(tx_req == 1'b0, "R12", "tx_req after reset", int'(tx_req), 0);
    chk(tx_en == 1'b0, "R12", "tx_en after reset", int'(tx_en), 0);
    step(5);
    chk(tx_req == 1'b0, "R12", "no pending after reset", int'(tx_req), 0);

    // R7 / R4: stop pin pulse gives one XOFF frame
    pin_xoff = 1; step(1); pin_xoff = 0;
    step(90);
    expect_seq("R7", '{32'h1234});

    // R7: resume pin held high gives exactly one XON frame
    pin_xon = 1; step(200); pin_xon = 0;
    step(10);
    expect_seq("R7", '{0});

    // R7 / R4: fill level crossing threshold, new pause time and address
    pause_quanta = 16'hBEEF; station_addr = 48'hF0E1D2C3B4A5;
    for (int v = 90; v <= 110; v += 5) begin fill_level = 12'(v); step(1); end
    step(150);
    fill_level = 12'd10;
    step(5);
    expect_seq("R7", '{32'hBEEF});

    // R7: resume control bit rising edge
    xon_wr = 1; step(100); xon_wr = 0;
    step(5);
    expect_seq("R7", '{0});

    // R10: stop and resume together
    pin_xoff = 1; pin_xon = 1; step(1); pin_xoff = 0; pin_xon = 0;
    step(170);
    expect_seq("R10", '{32'hBEEF, 0});

    // R9: delayed grant
    gnt_lat = 6;
    pin_xoff = 1; step(1); pin_xoff = 0;
    step(100);
    expect_seq("R9", '{32'hBEEF});
    gnt_lat = 0;

    // R11: resume arrives mid-frame
    pause_quanta = 16'h0042;
    pin_xoff = 1; step(1); pin_xoff = 0;
    step(30);
    pin_xon = 1; step(1); pin_xon = 0;
    step(170);
    expect_seq("R11", '{32'h0042, 0});

    // R8: continuous stop frames
    xoff_hold = 1; step(230); xoff_hold = 0;
    step(100);
    chk(obs_q.size() >= 3, "R8", "repeated frames", obs_q.size(), 3);
    for (int i = 0; i < obs_q.size(); i++)
      chk(obs_q[i] == 32'h0042, "R8", "repeat pause time", obs_q[i], 32'h0042);
    obs_q.delete();
    step(150);
    chk(obs_q.size() == 0, "R8", "no frame after clear", obs_q.size(), 0);

    // R9: request withdrawn before grant
    gnt_lat = 20;
    xoff_hold = 1; step(3); xoff_hold = 0;
    step(30);
    chk(tx_req == 1'b0, "R9", "request withdrawn", int'(tx_req), 0);
    step(100);
    chk(obs_q.size() == 0, "R9", "no frame after withdraw", obs_q.size(), 0);
    gnt_lat = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

endmodule